// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Queue

This block holds renamed instructions in an out-of-order core until their operands are available, then issues them to the execution units. Each arriving instruction has a sequence number, a class (integer, floating point, branch, memory or miscellaneous), up to two physical source tags with a valid flag each, and one destination tag. Operand state is tracked two ways. A per-register ready bit is cleared when a new producer is allocated and set when that producer's result is broadcast. Each waiting entry also watches the broadcast tag directly.

Every cycle the queue looks at all entries whose operands are ready. It grants up to three of them, oldest sequence number first. Each class has its own cap per cycle, and the three-grant total applies across all classes. Instructions marked non-speculative are held until the commit side names their sequence number. That release takes effect after a fixed pipeline delay. A squash names a sequence number, and every entry younger than it is dropped at once. The queue reports its free-entry count and a full flag, and it refuses inserts when full or while a squash is being presented.

Physical register tags are one flat index space: integer registers take the low indices and floating-point registers follow directly above them. The queue treats every tag identically.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty: `free_cnt` equals 16, `full` is 0, `in_ready` is 1 and no issue slot is valid. Every physical register reads as ready.
- R2: An insert is taken on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low while `full` is high or `sq_valid` is high. `full` is high exactly when `free_cnt` is 0, and a refused insert changes nothing.
- R3: Among eligible entries, grants go oldest first: slot 0 holds the smallest sequence number granted, and each later valid slot holds a larger one. Slots are filled from slot 0 without gaps.
- R4: Per-cycle class caps apply, using the class codes 0 integer, 1 floating point, 2 branch, 3 memory and 4 miscellaneous. At most 2 integer instructions are granted per cycle, and at most 1 of each other class. A capped older instruction does not block a younger one of another class.
- R5: At most 3 instructions are granted per cycle over all classes.
- R6: Accepting an insert clears the ready bit of its destination tag. An inserted instruction whose valid sources are all ready, with invalid sources counting as ready, is eligible from the cycle after insertion. Otherwise it waits.
- R7: A wakeup broadcast (`wk_valid`, `wk_tag`) sets that register's ready bit and marks the matching source of every queued entry ready. An entry whose sources are then all ready is eligible from the next cycle.
- R8: When a wakeup and an insert name the same source register in the same cycle, the inserted instruction sees that source as ready.
- R9: An entry inserted with `in_nonspec` set is not eligible until a release (`rel_valid`, `rel_seq`) names its sequence number. A release presented in cycle c makes the entry eligible from cycle c+3, which is the commit delay of 2 plus one.
- R10: With `sq_valid` high, every entry whose sequence number is greater than `sq_seq` is excluded from grants in that same cycle and is removed at the following edge.
- R11: A granted entry leaves the queue at the following edge. `free_cnt` then rises by the number of grants, less the number of inserts accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Insert request |
| in_ready | output | 1 | Insert can be taken this cycle |
| in_seq | input | 16 | Sequence number of the inserted instruction |
| in_cls | input | 3 | Instruction class code |
| in_nonspec | input | 1 | Hold until released by commit |
| in_src0_v | input | 1 | Source 0 is used |
| in_src0 | input | 6 | Source 0 physical tag |
| in_src1_v | input | 1 | Source 1 is used |
| in_src1 | input | 6 | Source 1 physical tag |
| in_dst | input | 6 | Destination physical tag |
| wk_valid | input | 1 | Result broadcast valid |
| wk_tag | input | 6 | Broadcast destination tag |
| rel_valid | input | 1 | Commit release valid |
| rel_seq | input | 16 | Sequence number released |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 16 | Entries younger than this are removed |
| iss_valid | output | 3 | Grant valid per slot |
| iss_seq | output | 48 | Sequence number per slot, slot k at bits 16k+15:16k |
| iss_cls | output | 9 | Class per slot, slot k at bits 3k+2:3k |
| iss_dst | output | 18 | Destination tag per slot, slot k at bits 6k+5:6k |
| free_cnt | output | 5 | Number of empty entries |
| full | output | 1 | No empty entry |

## Verification
A producer is followed by consumers inserted in descending sequence order and then released by a single wakeup. This exposes grant order that follows slot position instead of age, and it exercises class and total caps that were tested only one grant at a time. Separate directed runs cover the wakeup-plus-insert race on one tag, a non-speculative entry counted cycle by cycle against its release, and a full queue that is first squashed while blocked and then squashed in the same cycle its entries become ready. The last case separates removal from grant priority. A long random run mixes all inputs and compares every output each cycle against a behavioural queue model, which catches stale ready bits and lost releases that directed runs do not reach.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int NCLS  = 5;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT  = 3'd0,
    CLS_FP   = 3'd1,
    CLS_BR   = 3'd2,
    CLS_MEM  = 3'd3,
    CLS_MISC = 3'd4
  } iq_cls_e;
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
  parameter int PREGS = 64,
  localparam int TAG_W = $clog2(PREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wk_vld_i,
  input  logic [TAG_W-1:0] wk_tag_i,
  input  logic             alloc_vld_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  logic [TAG_W-1:0] rd0_tag_i,
  input  logic [TAG_W-1:0] rd1_tag_i,
  output logic             rd0_rdy_o,
  output logic             rd1_rdy_o
);
  logic [PREGS-1:0] rdy_q;
  logic [PREGS-1:0] rdy_d;
  logic             rdy_en;

  // broadcast sets first, a new allocation clears afterwards
  always_comb begin
    rdy_d = rdy_q;
    if (wk_vld_i)    rdy_d[wk_tag_i]    = 1'b1;
    if (alloc_vld_i) rdy_d[alloc_tag_i] = 1'b0;
  end

  assign rdy_en = wk_vld_i | alloc_vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= '1;
    else if (rdy_en) rdy_q <= rdy_d;
  end

  // same-cycle broadcast bypass for the insert path
  assign rd0_rdy_o = rdy_q[rd0_tag_i] | (wk_vld_i && (wk_tag_i == rd0_tag_i));
  assign rd1_rdy_o = rdy_q[rd1_tag_i] | (wk_vld_i && (wk_tag_i == rd1_tag_i));

  AST_WAKE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_vld_i && !(alloc_vld_i && alloc_tag_i == wk_tag_i)) |=> rdy_q[$past(wk_tag_i)]); // R7

  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld_i |=> !rdy_q[$past(alloc_tag_i)]); // R6
endmodule

// File: rtl/iq_release_pipe.sv
module iq_release_pipe #(
  parameter int SEQ_W = 16,
  parameter int DLY   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic             vld_o,
  output logic [SEQ_W-1:0] seq_o
);
  generate
    if (DLY == 0) begin : g_wire
      assign vld_o = vld_i;
      assign seq_o = seq_i;
    end else begin : g_pipe
      logic [DLY-1:0]            v_q;
      logic [DLY-1:0]            v_d;
      logic [DLY-1:0][SEQ_W-1:0] s_q;
      logic [DLY-1:0][SEQ_W-1:0] s_d;

      always_comb begin
        v_d[0] = vld_i;
        s_d[0] = seq_i;
        for (int i = 1; i < DLY; i++) begin
          v_d[i] = v_q[i-1];
          s_d[i] = s_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= '0;
          s_q <= '0;
        end else begin
          v_q <= v_d;
          for (int i = 0; i < DLY; i++) begin
            if (v_d[i]) s_q[i] <= s_d[i];
          end
        end
      end

      assign vld_o = v_q[DLY-1];
      assign seq_o = s_q[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/iq_select.sv
module iq_select
  import iq_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int SEQ_W    = 16,
  parameter int SLOTS    = 3,
  parameter int CAP_INT  = 2,
  parameter int CAP_FP   = 1,
  parameter int CAP_BR   = 1,
  parameter int CAP_MEM  = 1,
  parameter int CAP_MISC = 1,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            elig_i,
  input  logic [ENTRIES-1:0][SEQ_W-1:0] seq_i,
  input  logic [ENTRIES-1:0][CLS_W-1:0] cls_i,
  output logic [SLOTS-1:0]              pick_vld_o,
  output logic [SLOTS-1:0][IDX_W-1:0]   pick_idx_o
);
  function automatic int cap_of(logic [CLS_W-1:0] c);
    case (c)
      CLS_INT:  return CAP_INT;
      CLS_FP:   return CAP_FP;
      CLS_BR:   return CAP_BR;
      CLS_MEM:  return CAP_MEM;
      CLS_MISC: return CAP_MISC;
      default:  return 0;
    endcase
  endfunction

  // slot by slot: take the oldest remaining entry whose class has room
  always_comb begin
    logic [ENTRIES-1:0] taken;
    int                 used [2**CLS_W];
    logic               found;
    logic [IDX_W-1:0]   best;
    taken      = '0;
    pick_vld_o = '0;
    pick_idx_o = '0;
    for (int c = 0; c < 2**CLS_W; c++) used[c] = 0;
    for (int s = 0; s < SLOTS; s++) begin
      found = 1'b0;
      best  = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (elig_i[e] && !taken[e] && (used[cls_i[e]] < cap_of(cls_i[e]))) begin
          if (!found || (seq_i[e] < seq_i[best])) begin
            found = 1'b1;
            best  = IDX_W'(e);
          end
        end
      end
      pick_vld_o[s] = found;
      pick_idx_o[s] = best;
      if (found) begin
        taken[best]       = 1'b1;
        used[cls_i[best]] = used[cls_i[best]] + 1;
      end
    end
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue
  import iq_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int PREGS    = 64,
  parameter int SEQ_W    = 16,
  parameter int ISS_W    = 3,
  parameter int CMT_DLY  = 2,
  parameter int CAP_INT  = 2,
  parameter int CAP_FP   = 1,
  parameter int CAP_BR   = 1,
  parameter int CAP_MEM  = 1,
  parameter int CAP_MISC = 1,
  localparam int TAG_W = $clog2(PREGS),
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SEQ_W-1:0]       in_seq,
  input  logic [CLS_W-1:0]       in_cls,
  input  logic                   in_nonspec,
  input  logic                   in_src0_v,
  input  logic [TAG_W-1:0]       in_src0,
  input  logic                   in_src1_v,
  input  logic [TAG_W-1:0]       in_src1,
  input  logic [TAG_W-1:0]       in_dst,
  input  logic                   wk_valid,
  input  logic [TAG_W-1:0]       wk_tag,
  input  logic                   rel_valid,
  input  logic [SEQ_W-1:0]       rel_seq,
  input  logic                   sq_valid,
  input  logic [SEQ_W-1:0]       sq_seq,
  output logic [ISS_W-1:0]       iss_valid,
  output logic [ISS_W*SEQ_W-1:0] iss_seq,
  output logic [ISS_W*CLS_W-1:0] iss_cls,
  output logic [ISS_W*TAG_W-1:0] iss_dst,
  output logic [CNT_W-1:0]       free_cnt,
  output logic                   full
);
  localparam int CAPS [NCLS] = '{CAP_INT, CAP_FP, CAP_BR, CAP_MEM, CAP_MISC};

  typedef struct packed {
    logic             v;
    logic             hold;
    logic             r0;
    logic             r1;
    logic [SEQ_W-1:0] seq;
    logic [CLS_W-1:0] cls;
    logic [TAG_W-1:0] s0;
    logic [TAG_W-1:0] s1;
    logic [TAG_W-1:0] dst;
  } ent_t;

  ent_t [ENTRIES-1:0] ent_q;
  ent_t [ENTRIES-1:0] ent_d;
  logic [ENTRIES-1:0] ent_en;

  logic                            accept;
  logic                            alloc_found;
  logic [IDX_W-1:0]                alloc_idx;
  logic [CNT_W-1:0]                occ;
  logic                            src0_rdy;
  logic                            src1_rdy;
  logic                            rel_d_vld;
  logic [SEQ_W-1:0]                rel_d_seq;
  logic [ENTRIES-1:0]              younger;
  logic [ENTRIES-1:0]              elig;
  logic [ENTRIES-1:0][SEQ_W-1:0]   seq_v;
  logic [ENTRIES-1:0][CLS_W-1:0]   cls_v;
  logic [ISS_W-1:0]                pick_vld;
  logic [ISS_W-1:0][IDX_W-1:0]     pick_idx;
  logic [ENTRIES-1:0]              granted;
  logic [SEQ_W-1:0]                iss_seq_a [ISS_W];
  logic [CLS_W-1:0]                iss_cls_a [ISS_W];

  // ---------------- occupancy and insert admission ----------------
  always_comb begin
    occ         = '0;
    alloc_found = 1'b0;
    alloc_idx   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      occ = occ + CNT_W'(ent_q[e].v);
      if (!ent_q[e].v && !alloc_found) begin
        alloc_found = 1'b1;
        alloc_idx   = IDX_W'(e);
      end
    end
  end

  assign free_cnt = CNT_W'(ENTRIES) - occ;
  assign full     = !alloc_found;
  assign in_ready = !full && !sq_valid;
  assign accept   = in_valid && in_ready;

  iq_scoreboard #(.PREGS(PREGS)) u_sb (
    .clk        (clk),
    .rst_n      (rst_n),
    .wk_vld_i   (wk_valid),
    .wk_tag_i   (wk_tag),
    .alloc_vld_i(accept),
    .alloc_tag_i(in_dst),
    .rd0_tag_i  (in_src0),
    .rd1_tag_i  (in_src1),
    .rd0_rdy_o  (src0_rdy),
    .rd1_rdy_o  (src1_rdy)
  );

  iq_release_pipe #(.SEQ_W(SEQ_W), .DLY(CMT_DLY)) u_rel (
    .clk  (clk),
    .rst_n(rst_n),
    .vld_i(rel_valid),
    .seq_i(rel_seq),
    .vld_o(rel_d_vld),
    .seq_o(rel_d_seq)
  );

  // ---------------- eligibility and selection ----------------
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      younger[e] = sq_valid && (ent_q[e].seq > sq_seq);
      elig[e]    = ent_q[e].v && ent_q[e].r0 && ent_q[e].r1 && !ent_q[e].hold && !younger[e];
      seq_v[e]   = ent_q[e].seq;
      cls_v[e]   = ent_q[e].cls;
    end
  end

  iq_select #(
    .ENTRIES (ENTRIES),
    .SEQ_W   (SEQ_W),
    .SLOTS   (ISS_W),
    .CAP_INT (CAP_INT),
    .CAP_FP  (CAP_FP),
    .CAP_BR  (CAP_BR),
    .CAP_MEM (CAP_MEM),
    .CAP_MISC(CAP_MISC)
  ) u_sel (
    .elig_i    (elig),
    .seq_i     (seq_v),
    .cls_i     (cls_v),
    .pick_vld_o(pick_vld),
    .pick_idx_o(pick_idx)
  );

  always_comb begin
    granted = '0;
    for (int s = 0; s < ISS_W; s++) begin
      if (pick_vld[s]) granted[pick_idx[s]] = 1'b1;
      iss_valid[s]                 = pick_vld[s];
      iss_seq_a[s]                 = ent_q[pick_idx[s]].seq;
      iss_cls_a[s]                 = ent_q[pick_idx[s]].cls;
      iss_seq[s*SEQ_W +: SEQ_W]    = iss_seq_a[s];
      iss_cls[s*CLS_W +: CLS_W]    = iss_cls_a[s];
      iss_dst[s*TAG_W +: TAG_W]    = ent_q[pick_idx[s]].dst;
    end
  end

  // ---------------- entry next state ----------------
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      ent_d[e] = ent_q[e];
      if (ent_q[e].v) begin
        if (wk_valid && (ent_q[e].s0 == wk_tag)) ent_d[e].r0 = 1'b1;
        if (wk_valid && (ent_q[e].s1 == wk_tag)) ent_d[e].r1 = 1'b1;
        if (rel_d_vld && (ent_q[e].seq == rel_d_seq)) ent_d[e].hold = 1'b0;
        if (granted[e] || younger[e]) ent_d[e].v = 1'b0;
      end
      if (accept && (alloc_idx == IDX_W'(e))) begin
        ent_d[e].v    = 1'b1;
        ent_d[e].hold = in_nonspec;
        ent_d[e].r0   = !in_src0_v || src0_rdy;
        ent_d[e].r1   = !in_src1_v || src1_rdy;
        ent_d[e].seq  = in_seq;
        ent_d[e].cls  = in_cls;
        ent_d[e].s0   = in_src0;
        ent_d[e].s1   = in_src1;
        ent_d[e].dst  = in_dst;
      end
      ent_en[e] = ent_q[e].v || (accept && (alloc_idx == IDX_W'(e)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (ent_en[e]) ent_q[e] <= ent_d[e];
      end
    end
  end

  // ---------------- assertions ----------------
  AST_FREE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sq_valid) |-> (int'(free_cnt) + int'($past(accept)) ==
                          int'($past(free_cnt)) + $countones($past(iss_valid)))); // R11

  generate
    for (genvar k = 0; k < ISS_W; k++) begin : g_slot_chk
      AST_SQUASH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && iss_valid[k]) |-> (iss_seq_a[k] <= sq_seq)); // R10
      if (k > 0) begin : g_ord
        AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
          iss_valid[k] |-> (iss_valid[k-1] && (iss_seq_a[k-1] < iss_seq_a[k]))); // R3
      end
    end
    for (genvar c = 0; c < NCLS; c++) begin : g_cls_chk
      logic [ISS_W-1:0] hit;
      always_comb begin
        for (int s = 0; s < ISS_W; s++) hit[s] = iss_valid[s] && (iss_cls_a[s] == CLS_W'(c));
      end
      AST_CLASS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit) <= CAPS[c]); // R4
    end
  endgenerate
endmodule

// File: tb/issue_queue_bench.sv
`timescale 1ns/1ps
module issue_queue_bench;
  localparam int ENT   = 16;
  localparam int ISS_W = 3;
  localparam int SEQ_W = 16;
  localparam int TAG_W = 6;
  localparam int PREGS = 64;
  localparam int DLY   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_nonspec = 0, in_src0_v = 0, in_src1_v = 0;
  logic [SEQ_W-1:0] in_seq = '0;
  logic [2:0] in_cls = '0;
  logic [TAG_W-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0, wk_tag = '0;
  logic wk_valid = 0, rel_valid = 0, sq_valid = 0;
  logic [SEQ_W-1:0] rel_seq = '0, sq_seq = '0;
  logic in_ready, full;
  logic [ISS_W-1:0] iss_valid;
  logic [ISS_W*SEQ_W-1:0] iss_seq;
  logic [ISS_W*3-1:0] iss_cls;
  logic [ISS_W*TAG_W-1:0] iss_dst;
  logic [4:0] free_cnt;

  always #2 clk = ~clk;

  issue_queue u_issue_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_seq(in_seq), .in_cls(in_cls), .in_nonspec(in_nonspec),
    .in_src0_v(in_src0_v), .in_src0(in_src0), .in_src1_v(in_src1_v), .in_src1(in_src1),
    .in_dst(in_dst), .wk_valid(wk_valid), .wk_tag(wk_tag),
    .rel_valid(rel_valid), .rel_seq(rel_seq), .sq_valid(sq_valid), .sq_seq(sq_seq),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_cls(iss_cls), .iss_dst(iss_dst),
    .free_cnt(free_cnt), .full(full)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit done = 0;
  bit last_acc = 0;

  typedef struct {
    int seq; int cls; bit hold; bit r0; bit r1; int s0; int s1; int dst;
  } ment_t;
  ment_t mq[$];
  bit sb [PREGS];
  bit pv [DLY];
  int ps [DLY];

  function automatic int capf(int c);
    return (c == 0) ? 2 : ((c <= 4) ? 1 : 0);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int slot_seq(int k); return int'(iss_seq[k*SEQ_W +: SEQ_W]); endfunction

  task automatic defaults();
    in_valid = 0; in_nonspec = 0; in_src0_v = 0; in_src1_v = 0;
    wk_valid = 0; rel_valid = 0; sq_valid = 0;
  endtask

  task automatic ins(input int seq, input int cls, input bit ns,
                     input bit v0, input int t0, input bit v1, input int t1, input int dst);
    in_valid = 1; in_seq = SEQ_W'(seq); in_cls = 3'(cls); in_nonspec = ns;
    in_src0_v = v0; in_src0 = TAG_W'(t0); in_src1_v = v1; in_src1 = TAG_W'(t1);
    in_dst = TAG_W'(dst);
  endtask

  // reference model: compare outputs, then advance the model over the edge
  task automatic at_neg();
    int n; bit efull; bit erdy; bit acc;
    int el[$]; int used[8]; int tot; bit pk[ENT];
    bit ev[ISS_W]; int es[ISS_W]; int ec[ISS_W]; int ed[ISS_W];
    ment_t nq[$]; ment_t ne;
    @(negedge clk);
    n = mq.size(); efull = (n == ENT); erdy = !efull && !sq_valid;
    chk(cur_req, "free_cnt", free_cnt, ENT - n);
    chk(cur_req, "full", full, efull);
    chk(cur_req, "in_ready", in_ready, erdy);
    for (int i = 0; i < n; i++) begin
      pk[i] = 0;
      if (mq[i].r0 && mq[i].r1 && !mq[i].hold && !(sq_valid && mq[i].seq > int'(sq_seq)))
        el.push_back(i);
    end
    for (int a = 1; a < el.size(); a++) begin
      for (int b = a; b > 0; b--) begin
        if (mq[el[b]].seq < mq[el[b-1]].seq) begin
          int t = el[b]; el[b] = el[b-1]; el[b-1] = t;
        end
      end
    end
    for (int c = 0; c < 8; c++) used[c] = 0;
    for (int k = 0; k < ISS_W; k++) begin ev[k] = 0; es[k] = 0; ec[k] = 0; ed[k] = 0; end
    tot = 0;
    foreach (el[j]) begin
      int i = el[j];
      if (tot < ISS_W && used[mq[i].cls] < capf(mq[i].cls)) begin
        ev[tot] = 1; es[tot] = mq[i].seq; ec[tot] = mq[i].cls; ed[tot] = mq[i].dst;
        used[mq[i].cls]++; tot++; pk[i] = 1;
      end
    end
    for (int k = 0; k < ISS_W; k++) begin
      chk(cur_req, $sformatf("slot%0d valid", k), iss_valid[k], ev[k]);
      if (ev[k] && iss_valid[k]) begin
        chk(cur_req, $sformatf("slot%0d seq", k), slot_seq(k), es[k]);
        chk(cur_req, $sformatf("slot%0d cls", k), iss_cls[k*3 +: 3], ec[k]);
        chk(cur_req, $sformatf("slot%0d dst", k), iss_dst[k*TAG_W +: TAG_W], ed[k]);
      end
    end
    acc = in_valid && erdy;
    for (int i = 0; i < n; i++) begin
      ment_t e;
      if (pk[i] || (sq_valid && mq[i].seq > int'(sq_seq))) continue;
      e = mq[i];
      if (wk_valid && e.s0 == int'(wk_tag)) e.r0 = 1;
      if (wk_valid && e.s1 == int'(wk_tag)) e.r1 = 1;
      if (pv[DLY-1] && ps[DLY-1] == e.seq) e.hold = 0;
      nq.push_back(e);
    end
    if (acc) begin
      ne.seq = int'(in_seq); ne.cls = int'(in_cls); ne.hold = in_nonspec;
      ne.s0 = int'(in_src0); ne.s1 = int'(in_src1); ne.dst = int'(in_dst);
      ne.r0 = !in_src0_v || sb[in_src0] || (wk_valid && wk_tag == in_src0);
      ne.r1 = !in_src1_v || sb[in_src1] || (wk_valid && wk_tag == in_src1);
      nq.push_back(ne);
    end
    mq = nq;
    if (wk_valid) sb[wk_tag] = 1;
    if (acc) sb[in_dst] = 0;
    for (int k = DLY - 1; k > 0; k--) begin pv[k] = pv[k-1]; ps[k] = ps[k-1]; end
    pv[0] = rel_valid; ps[0] = int'(rel_seq);
    last_acc = acc;
  endtask

  task automatic fin();
    @(posedge clk); #1;
    defaults();
  endtask

  task automatic cyc(); at_neg(); fin(); endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int nseq;
    for (int r = 0; r < PREGS; r++) sb[r] = 1;
    for (int k = 0; k < DLY; k++) begin pv[k] = 0; ps[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    cur_req = "R1";
    at_neg();
    chk("R1", "free after reset", free_cnt, 16);
    chk("R1", "full after reset", full, 0);
    chk("R1", "ready after reset", in_ready, 1);
    chk("R1", "no issue after reset", iss_valid, 0);
    fin();

    // R6 R3 R4 R5: consumers inserted youngest first, released by one wakeup
    cur_req = "R6";
    ins(100, 0, 0, 0, 0, 0, 0, 20); cyc();
    ins(90, 0, 0, 1, 20, 0, 0, 1); cyc();
    ins(80, 0, 0, 1, 20, 0, 0, 2); at_neg(); chk("R6", "blocked consumers", iss_valid, 0); fin();
    ins(75, 0, 0, 1, 20, 0, 0, 3); at_neg(); chk("R6", "blocked consumers", iss_valid, 0); fin();
    ins(70, 0, 0, 0, 0, 1, 20, 4); at_neg(); chk("R6", "blocked consumers", iss_valid, 0); fin();
    ins(60, 1, 0, 1, 20, 0, 0, 5); cyc();
    ins(50, 2, 0, 1, 20, 0, 0, 6); cyc();
    cur_req = "R7";
    wk_valid = 1; wk_tag = 20;
    at_neg(); chk("R7", "no issue in wakeup cycle", iss_valid, 0); fin();
    cur_req = "R5";
    at_neg();
    chk("R5", "three grants", iss_valid, 3'b111);
    chk("R3", "oldest in slot0", slot_seq(0), 50);
    chk("R3", "slot1 seq", slot_seq(1), 60);
    chk("R3", "slot2 seq", slot_seq(2), 70);
    fin();
    cur_req = "R4";
    at_neg();
    chk("R4", "integer cap grants", iss_valid, 3'b011);
    chk("R4", "int slot0", slot_seq(0), 75);
    chk("R4", "int slot1", slot_seq(1), 80);
    fin();
    at_neg(); chk("R4", "last int", slot_seq(0), 90); fin();

    // R8: wakeup and insert on the same tag
    cur_req = "R8";
    ins(200, 0, 0, 0, 0, 0, 0, 30); cyc();
    ins(201, 0, 0, 1, 30, 0, 0, 7); wk_valid = 1; wk_tag = 30; cyc();
    at_neg();
    chk("R8", "bypassed insert issues", iss_valid, 3'b001);
    chk("R8", "bypassed seq", slot_seq(0), 201);
    fin();

    // R9: non-speculative hold and release delay
    cur_req = "R9";
    ins(300, 3, 1, 0, 0, 0, 0, 8); cyc();
    for (int i = 0; i < 3; i++) begin at_neg(); chk("R9", "held before release", iss_valid, 0); fin(); end
    rel_valid = 1; rel_seq = 300;
    for (int i = 0; i < 3; i++) begin at_neg(); chk("R9", "held inside delay", iss_valid, 0); fin(); end
    at_neg();
    chk("R9", "issue at release+3", iss_valid, 3'b001);
    chk("R9", "released seq", slot_seq(0), 300);
    fin();

    // R2 R10 R11: fill, refuse, squash while blocked, squash at grant
    cur_req = "R2";
    ins(399, 0, 0, 0, 0, 0, 0, 40); cyc();
    for (int k = 0; k < 16; k++) begin ins(400 + k, 0, 0, 1, 40, 0, 0, 9); cyc(); end
    ins(416, 0, 0, 0, 0, 0, 0, 10);
    at_neg();
    chk("R2", "full flag", full, 1);
    chk("R2", "ready low when full", in_ready, 0);
    chk("R2", "free zero", free_cnt, 0);
    fin();
    cur_req = "R10";
    sq_valid = 1; sq_seq = 407;
    at_neg(); chk("R10", "ready low during squash", in_ready, 0); fin();
    wk_valid = 1; wk_tag = 40;
    at_neg(); chk("R10", "free after squash", free_cnt, 8); fin();
    sq_valid = 1; sq_seq = 400;
    at_neg();
    chk("R10", "only older entry granted", iss_valid, 3'b001);
    chk("R10", "granted seq", slot_seq(0), 400);
    fin();
    cur_req = "R11";
    at_neg(); chk("R11", "emptied", free_cnt, 16); fin();

    // random mix against the model
    cur_req = "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11";
    nseq = 1000;
    for (int c = 0; c < 4000; c++) begin
      ins(nseq, int'($urandom % 5), ($urandom % 8) == 0,
          $urandom % 2, int'($urandom % 16), $urandom % 2, int'($urandom % 16),
          int'($urandom % 16));
      in_valid = ($urandom % 4) != 0;
      wk_valid = $urandom % 2; wk_tag = TAG_W'($urandom % 16);
      if (mq.size() > 0 && ($urandom % 3) == 0) begin
        int j = int'($urandom % mq.size());
        if (mq[j].hold) begin rel_valid = 1; rel_seq = SEQ_W'(mq[j].seq); end
      end
      if (($urandom % 40) == 0) begin
        sq_valid = 1; sq_seq = SEQ_W'(nseq - 1 - int'($urandom % 6));
      end
      at_neg();
      if (last_acc) nseq++;
      fin();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule